// File: doc/BRIEF.md
# Deferred Condition Flag Evaluator

This block turns a postponed flag computation into a concrete condition-flag word. An execution pipeline that does not compute flags after every instruction saves three things instead: a class code for the operation, the result word, and one source operand. When a later instruction needs the flags, it presents these saved values to this block with a request strobe. One clock later the block returns the rebuilt N, Z, V and C flags, together with the extend flag carried through from an input.

The block only has the result and one operand. It recovers the missing operand by arithmetic: for subtraction it adds the source back to the result, and for addition it subtracts the source from the result. Shift classes use the shift count as the saved source word. Counts of 32 or more give fixed N/Z values. The carry is the last bit shifted out, and it is produced only for counts from 1 to 32. Byte and word compares run the subtract rule at 8 and 16 bits.

Top module: `lcc_flag_eval`

## Requirements
- R1: After reset, flags_o, valid_o and err_o are all 0. A request sampled at a rising edge sets valid_o high for exactly the following cycle and updates flags_o in that same cycle. With req_i low, valid_o is 0.
- R2: Flag word layout: bit 0 is C, bit 1 is V, bit 2 is Z, bit 3 is N and bit 4 is X. Class code 0 (stored) copies bits 4..0 of res_i to flags_o unchanged.
- R3: For every class except stored, Z is set when the evaluated value is zero. Otherwise N is set when the value's sign bit is 1. N and Z are never both set.
- R4: For every class except stored, flag bit 4 equals x_i as sampled with the request.
- R5: Class 1 (logic) takes N and Z from res_i and clears V and C.
- R6: Class 2 (add) sets C when res_i < src_i unsigned. V is bit 31 of (src^res) & ~((res-src)^src).
- R7: Class 3 (subtract) rebuilds t = res+src. C is set when t < src unsigned, and V is bit 31 of (t^res)&(t^src).
- R8: Classes 4 (byte compare) and 5 (word compare) apply the R7 rule to the low 8 or 16 bits only, and take N and Z from those bits. Upper bits have no effect.
- R9: Class 6 (add-extended) sets C when res <= src unsigned. V is computed as in R6, but with t = res-src-1.
- R10: Class 7 (subtract-extended) uses t = res+src+1. C is set when t <= src, and V is bit 31 of (t^res)&(t^src).
- R11: Classes 8 (shift left), 9 (logical shift right) and 10 (arithmetic shift right) use src_i as the count. Below 32, N and Z come from the shifted value. At 32 or more, N and Z come from zero for classes 8 and 9, and from all ones for class 10. V is 0.
- R12: The shift carry is set only for counts 1 to 32. For a left shift it is bit (32-count) of res_i. For a right shift it is bit (count-1) of res_i, sign-extended for the arithmetic class. A zero count clears C.
- R13: Class codes 11 to 15 raise err_o for one cycle, keep valid_o low, and leave flags_o unchanged.
- R14: Each request is evaluated from that cycle's inputs alone. Back-to-back requests give back-to-back results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Evaluate request |
| op_i | input | 4 | Deferred operation class code |
| res_i | input | 32 | Saved result word |
| src_i | input | 32 | Saved source operand or shift count |
| x_i | input | 1 | Extend flag to carry into bit 4 |
| flags_o | output | 5 | Registered flag word {X,N,Z,V,C} |
| valid_o | output | 1 | Flag word updated this cycle |
| err_o | output | 1 | Undefined class code seen |

## Verification
The bench targets these corner cases:
- Signed overflow across the 0x7FFFFFFF/0x80000000 boundary for add and subtract. A swapped operand recovery would miss this V or flag it falsely.
- Narrow compares where the upper bits would change N, or would make Z look false. A design that evaluated at 32 bits would fail these.
- Shift counts of 0, 1, 32 and above 32, including an arithmetic shift of zero by 40, which must still report N. A wrong carry index or a missing range test shows up as a stray C or an absent C.
- Undefined codes, where a design that loaded its computed value would corrupt the held flag word.

// File: rtl/lcc_pkg.sv
package lcc_pkg;

    typedef enum logic [3:0] {
        OP_STORED = 4'd0,
        OP_LOGIC  = 4'd1,
        OP_ADD    = 4'd2,
        OP_SUB    = 4'd3,
        OP_CMP8   = 4'd4,
        OP_CMP16  = 4'd5,
        OP_ADDX   = 4'd6,
        OP_SUBX   = 4'd7,
        OP_SHL    = 4'd8,
        OP_SHR    = 4'd9,
        OP_SAR    = 4'd10
    } op_e;

    localparam int FLAG_W = 5;

    typedef struct packed {
        logic [FLAG_W-1:0] flags;
        logic              valid;
        logic              err;
    } out_t;

endpackage

// File: rtl/lcc_subcore.sv
// Subtract-style flag rule at one width: first operand rebuilt as res + src.
module lcc_subcore #(
    parameter int W = 32
) (
    input  logic [W-1:0] res_i,
    input  logic [W-1:0] src_i,
    output logic         n_o,
    output logic         z_o,
    output logic         v_o,
    output logic         c_o
);
    logic [W-1:0] t;
    logic [W-1:0] ovf;

    always_comb begin
        t   = res_i + src_i;
        ovf = (t ^ res_i) & (t ^ src_i);
        z_o = (res_i == '0);
        n_o = !z_o && res_i[W-1];
        v_o = ovf[W-1];
        c_o = (t < src_i);
    end
endmodule

// File: rtl/lcc_arith.sv
// Arithmetic classes: add, subtract, narrow compares, extended forms.
module lcc_arith #(
    parameter int W = 32
) (
    input  logic [3:0]   op_i,
    input  logic [W-1:0] res_i,
    input  logic [W-1:0] src_i,
    output logic [3:0]   nzvc_o
);
    import lcc_pkg::*;

    localparam int NCORE = 3;

    logic [NCORE-1:0] sn, sz, sv, sc;

    for (genvar g = 0; g < NCORE; g++) begin : g_core
        localparam int WD = (g == 0) ? W : ((g == 1) ? 16 : 8);
        lcc_subcore #(.W(WD)) u_core (
            .res_i (res_i[WD-1:0]),
            .src_i (src_i[WD-1:0]),
            .n_o   (sn[g]),
            .z_o   (sz[g]),
            .v_o   (sv[g]),
            .c_o   (sc[g])
        );
    end

    logic         rz, rn;
    logic [W-1:0] add_t, add_ov, adx_t, adx_ov, sbx_t, sbx_ov;

    always_comb begin
        rz     = (res_i == '0);
        rn     = !rz && res_i[W-1];
        add_t  = res_i - src_i;
        add_ov = (src_i ^ res_i) & ~(add_t ^ src_i);
        adx_t  = res_i - src_i - 1'b1;
        adx_ov = (src_i ^ res_i) & ~(adx_t ^ src_i);
        sbx_t  = res_i + src_i + 1'b1;
        sbx_ov = (sbx_t ^ res_i) & (sbx_t ^ src_i);

        unique case (op_e'(op_i))
            OP_ADD:   nzvc_o = {rn, rz, add_ov[W-1], res_i < src_i};
            OP_SUB:   nzvc_o = {sn[0], sz[0], sv[0], sc[0]};
            OP_CMP16: nzvc_o = {sn[1], sz[1], sv[1], sc[1]};
            OP_CMP8:  nzvc_o = {sn[2], sz[2], sv[2], sc[2]};
            OP_ADDX:  nzvc_o = {rn, rz, adx_ov[W-1], res_i <= src_i};
            OP_SUBX:  nzvc_o = {rn, rz, sbx_ov[W-1], sbx_t <= src_i};
            default:  nzvc_o = 4'b0000;
        endcase
    end
endmodule

// File: rtl/lcc_shift.sv
// Shift classes: N/Z with saturation at W, carry = last bit shifted out.
module lcc_shift #(
    parameter int W = 32
) (
    input  logic [3:0]   op_i,
    input  logic [W-1:0] val_i,
    input  logic [W-1:0] cnt_i,
    output logic         n_o,
    output logic         z_o,
    output logic         c_o
);
    import lcc_pkg::*;

    localparam int           CW = $clog2(W);
    localparam logic [W-1:0] WL = W'(W);
    localparam logic [CW:0]  WS = (CW + 1)'(W);

    logic          big, in_rng, is_sar, is_left;
    logic [CW:0]   cnt_s, dl, dr;
    logic [W-1:0]  shv, ev;

    always_comb begin
        is_sar  = (op_e'(op_i) == OP_SAR);
        is_left = (op_e'(op_i) == OP_SHL);
        big     = (cnt_i >= WL);
        in_rng  = (cnt_i != '0) && (cnt_i <= WL);
        cnt_s   = cnt_i[CW:0];
        dl      = WS - cnt_s;
        dr      = cnt_s - 1'b1;

        if (is_left)
            shv = val_i << cnt_i[CW-1:0];
        else if (is_sar)
            shv = $unsigned($signed(val_i) >>> cnt_i[CW-1:0]);
        else
            shv = val_i >> cnt_i[CW-1:0];

        if (big)
            ev = is_sar ? '1 : '0;
        else
            ev = shv;

        z_o = (ev == '0);
        n_o = !z_o && ev[W-1];

        if (!in_rng)
            c_o = 1'b0;
        else if (is_left)
            c_o = val_i[dl[CW-1:0]];
        else
            c_o = val_i[dr[CW-1:0]];
    end
endmodule

// File: rtl/lcc_flag_eval.sv
module lcc_flag_eval #(
    parameter int W = 32
) (
    input  logic                      clk_i,
    input  logic                      rst_ni,
    input  logic                      req_i,
    input  logic [3:0]                op_i,
    input  logic [W-1:0]              res_i,
    input  logic [W-1:0]              src_i,
    input  logic                      x_i,
    output logic [lcc_pkg::FLAG_W-1:0] flags_o,
    output logic                      valid_o,
    output logic                      err_o
);
    import lcc_pkg::*;

    logic [3:0] ar_nzvc;
    logic       sh_n, sh_z, sh_c, lg_z, lg_n;
    out_t       st_d, st_q;

    lcc_arith #(.W(W)) u_arith (
        .op_i   (op_i),
        .res_i  (res_i),
        .src_i  (src_i),
        .nzvc_o (ar_nzvc)
    );

    lcc_shift #(.W(W)) u_shift (
        .op_i  (op_i),
        .val_i (res_i),
        .cnt_i (src_i),
        .n_o   (sh_n),
        .z_o   (sh_z),
        .c_o   (sh_c)
    );

    always_comb begin
        lg_z        = (res_i == '0);
        lg_n        = !lg_z && res_i[W-1];
        st_d        = st_q;
        st_d.valid  = 1'b0;
        st_d.err    = 1'b0;
        if (req_i) begin
            st_d.valid = 1'b1;
            unique case (op_e'(op_i))
                OP_STORED: st_d.flags = res_i[FLAG_W-1:0];
                OP_LOGIC:  st_d.flags = {x_i, lg_n, lg_z, 2'b00};
                OP_ADD, OP_SUB, OP_CMP8, OP_CMP16, OP_ADDX, OP_SUBX:
                           st_d.flags = {x_i, ar_nzvc};
                OP_SHL, OP_SHR, OP_SAR:
                           st_d.flags = {x_i, sh_n, sh_z, 1'b0, sh_c};
                default: begin
                    st_d.valid = 1'b0;
                    st_d.err   = 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign flags_o = st_q.flags;
    assign valid_o = st_q.valid;
    assign err_o   = st_q.err;
endmodule

// File: rtl/lcc_flag_eval_chk.sv
module lcc_flag_eval_chk #(
    parameter int W = 32
) (
    input logic         clk_i,
    input logic         rst_ni,
    input logic         req_i,
    input logic [3:0]   op_i,
    input logic [W-1:0] res_i,
    input logic         x_i,
    input logic [4:0]   flags_o,
    input logic         valid_o,
    input logic         err_o
);
    AST_VALID_FROM_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_o |-> $past(req_i));                                          // R1
    AST_STORED_COPY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_o && $past(op_i) == 4'd0) |-> flags_o == $past(res_i[4:0])); // R2
    AST_NZ_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_o && $past(op_i) != 4'd0) |-> !(flags_o[3] && flags_o[2]));  // R3
    AST_X_CARRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_o && $past(op_i) != 4'd0) |-> flags_o[4] == $past(x_i));     // R4
    AST_LOGIC_VC_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_o && $past(op_i) == 4'd1) |-> flags_o[1:0] == 2'b00);        // R5
    AST_SHIFT_V_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_o && $past(op_i) >= 4'd8) |-> !flags_o[1]);                  // R11
    AST_ERR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        err_o |-> ($stable(flags_o) && !valid_o));                          // R13
    AST_ERR_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        err_o |-> ($past(req_i) && $past(op_i) >= 4'd11));                  // R13
endmodule

bind lcc_flag_eval lcc_flag_eval_chk #(.W(W)) u_chk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (req_i),
    .op_i    (op_i),
    .res_i   (res_i),
    .x_i     (x_i),
    .flags_o (flags_o),
    .valid_o (valid_o),
    .err_o   (err_o)
);

// File: tb/lcc_flag_eval_test.sv
`timescale 1ns/1ps
module lcc_flag_eval_test;

    typedef struct packed {
        logic [3:0]  op;
        logic [31:0] res;
        logic [31:0] src;
        logic        x;
        logic [4:0]  exp;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VEC [NV] = '{
        '{4'd0,  32'h0000_001B, 32'h0000_0000, 1'b0, 5'h1B},
        '{4'd1,  32'h0000_0000, 32'h1234_5678, 1'b1, 5'h14},
        '{4'd1,  32'h8000_0000, 32'h0000_0000, 1'b0, 5'h08},
        '{4'd2,  32'h8000_0000, 32'h0000_0001, 1'b0, 5'h0A},
        '{4'd2,  32'h0000_0001, 32'h0000_0002, 1'b1, 5'h11},
        '{4'd3,  32'hFFFF_FFFF, 32'h0000_0001, 1'b0, 5'h09},
        '{4'd3,  32'h7FFF_FFFF, 32'h0000_0001, 1'b0, 5'h02},
        '{4'd4,  32'hABCD_0000, 32'h1234_5605, 1'b0, 5'h04},
        '{4'd5,  32'hFFFF_7FFF, 32'h0000_0001, 1'b0, 5'h02},
        '{4'd6,  32'h0000_0005, 32'h0000_0005, 1'b0, 5'h01},
        '{4'd7,  32'hFFFF_FFFF, 32'h0000_0000, 1'b0, 5'h09},
        '{4'd8,  32'h8000_0000, 32'h0000_0000, 1'b0, 5'h08},
        '{4'd8,  32'h8000_0001, 32'h0000_0001, 1'b0, 5'h01},
        '{4'd8,  32'h0000_0001, 32'h0000_0020, 1'b0, 5'h05},
        '{4'd8,  32'h0000_0001, 32'h0000_0021, 1'b0, 5'h04},
        '{4'd9,  32'h0000_00F8, 32'h0000_0004, 1'b1, 5'h11},
        '{4'd9,  32'h8000_0000, 32'h0000_0020, 1'b0, 5'h05},
        '{4'd10, 32'h8000_0000, 32'h0000_0020, 1'b0, 5'h09},
        '{4'd10, 32'h0000_0000, 32'h0000_0028, 1'b0, 5'h08},
        '{4'd10, 32'h8000_0000, 32'h0000_0004, 1'b0, 5'h08}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic [3:0]  op = '0;
    logic [31:0] res = '0;
    logic [31:0] src = '0;
    logic        x = 1'b0;
    logic [4:0]  flags;
    logic        valid, err;
    int          n_chk = 0;
    int          n_bad = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    lcc_flag_eval uut (
        .clk_i   (clk),
        .rst_ni  (rst_n),
        .req_i   (req),
        .op_i    (op),
        .res_i   (res),
        .src_i   (src),
        .x_i     (x),
        .flags_o (flags),
        .valid_o (valid),
        .err_o   (err)
    );

    function automatic string tag_of(logic [3:0] c);
        case (c)
            4'd0:  return "R2";
            4'd1:  return "R5 R3 R4";
            4'd2:  return "R6 R4";
            4'd3:  return "R7 R3";
            4'd4,
            4'd5:  return "R8";
            4'd6:  return "R9";
            4'd7:  return "R10";
            default: return "R11 R12";
        endcase
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic drive(logic [3:0] c, logic [31:0] r, logic [31:0] s, logic xv);
        @(negedge clk);
        req = 1'b1; op = c; res = r; src = s; x = xv;
        @(negedge clk);
    endtask

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [4:0] held;
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 reset flags", 32'(flags), 32'h0);
        check("R1 reset valid", 32'(valid), 32'h0);
        check("R1 reset err", 32'(err), 32'h0);
        rst_n = 1'b1;

        // table walk, back to back (R14)
        for (int i = 0; i < NV; i++) begin
            drive(VEC[i].op, VEC[i].res, VEC[i].src, VEC[i].x);
            check({tag_of(VEC[i].op), " R14 flags"}, 32'(flags), 32'(VEC[i].exp));
            check("R1 valid", 32'(valid), 32'h1);
        end

        // R1: strobe drops without a request
        @(negedge clk);
        req = 1'b0;
        @(negedge clk);
        check("R1 valid idle", 32'(valid), 32'h0);
        check("R1 flags held idle", 32'(flags), 32'h08);

        // R13: undefined codes keep flags
        held = flags;
        drive(4'd11, 32'hFFFF_FFFF, 32'h0, 1'b1);
        check("R13 err", 32'(err), 32'h1);
        check("R13 valid low", 32'(valid), 32'h0);
        check("R13 flags held", 32'(flags), 32'(held));
        drive(4'd15, 32'h0, 32'h0, 1'b1);
        check("R13 err code 15", 32'(err), 32'h1);
        check("R13 flags held 15", 32'(flags), 32'(held));

        // R3 R4: recovery after error, zero result with x set
        drive(4'd3, 32'h0, 32'h0, 1'b1);
        check("R3 R4 sub zero", 32'(flags), 32'h14);
        check("R13 err clears", 32'(err), 32'h0);

        // R12: left shift by 32 of a value with bit 0 clear gives no carry
        drive(4'd8, 32'hFFFF_FFFE, 32'h0000_0020, 1'b0);
        check("R12 shl 32 no carry", 32'(flags), 32'h04);

        @(negedge clk);
        req = 1'b0;
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule